// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a local-bus address into a PCI bus address using three programmable windows. Each window is a pair of registers: a base register that says which local range the window claims, how large it is and whether it is enabled, and a map register that gives the PCI address the range lands on and the kind of bus cycle to run. Every incoming address is compared against all enabled windows at once. The lowest-numbered window that claims it is used. The block reports the translated address, the cycle type, whether PCI A1:A0 come from the local address or are driven low, the window's prefetchable attribute, the index of the window used, and a miss flag when no window claims the address.

Windows may overlap, and the fixed priority lets software use that on purpose. When window 0 grows from 256 MB to 512 MB it covers the range window 1 held. Window 1 can then be pointed at configuration space at another local address, and the memory traffic is not disturbed. Window 2 has a simpler layout reserved for I/O space. Registers are loaded through a single-cycle write port. A write takes effect from the next clock edge, and translation is purely combinational from the registered state.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset all six registers are zero, so every window is disabled and `miss` is 1 for any address.
- R2: A write with `wr_en`=1 stores `wr_data` into the register chosen by `wr_sel` (0 = base 0, 1 = map 0, 2 = base 1, 3 = map 1, 4 = base 2, 5 = map 2) at the next rising clock edge. Until that edge the outputs reflect the old value. Selector values 6 and 7 change nothing.
- R3: In windows 0 and 1, base bit 0 enables the window, bits 7:4 hold a size code s giving a size of 1 MB << s, and bits 31:20 hold the local base. Code 4 is 16 MB, 8 is 256 MB and 9 is 512 MB, and any code above 9 acts as 9. An address matches when it lies in the size-aligned range that contains the base. A disabled window never matches.
- R4: When several enabled windows match, the one with the lowest index is used and `hit_win` gives that index.
- R5: The translated address takes the map's upper bits above the window size and passes the local address bits below the window size unchanged.
- R6: For windows 0 and 1, `cyc_type` equals map bits 3:1. The encodings are 011 memory, 111 memory-multiple (prefetchable) and 101 configuration.
- R7: For windows 0 and 1, map bit 0 drives `ad_low_en`. When it is 0, `pci_addr[1:0]` is 00. When it is 1, those bits come from the local address.
- R8: Window 2 is an I/O window of fixed 16 MB size. Base bit 0 enables it and base bits 31:24 give the local base. Map bits 31:24 give the PCI upper bits. Its `cyc_type` is always 001 and `ad_low_en` is always 1, and the map's low bits are ignored.
- R9: Base bit 2 of windows 0 and 1 is reported on `prefetch` when that window is used. Window 2 always reports 0.
- R10: When no enabled window matches, `miss`=1, `hit_win`=3, and `pci_addr`, `cyc_type`, `ad_low_en` and `prefetch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector |
| wr_data | input | 32 | Register write value |
| lb_addr | input | 32 | Local-bus address to translate |
| pci_addr | output | 32 | Translated PCI address |
| cyc_type | output | 3 | PCI cycle type of the chosen window |
| ad_low_en | output | 1 | 1: A1:A0 pass through, 0: forced low |
| prefetch | output | 1 | Prefetchable attribute of the chosen window |
| hit_win | output | 2 | Index of the chosen window, 3 on a miss |
| miss | output | 1 | No enabled window matches |

## Verification
A register write and a translation can land in the same cycle, even when the write rewrites the window that currently claims the address. The bench provokes this by presenting an address and asserting a write in the same low clock phase. It checks that the outputs still follow the old window before the edge and the new one after it. The second overlap is two windows claiming one address at once. This is provoked by growing window 0 over window 1 and by random bases that land close together, and it is judged against a bench model that walks the windows in index order.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int ADDR_W    = 32;
    localparam int NUM_WIN   = 3;
    localparam int NUM_REGS  = 2 * NUM_WIN;
    localparam int SEL_W     = $clog2(NUM_REGS + 2);
    localparam int IDX_W     = $clog2(NUM_WIN + 1);
    localparam int IO_WIN    = NUM_WIN - 1;
    localparam int MIN_SHIFT = 20;
    localparam int MAX_CODE  = 9;
    localparam int IO_SHIFT  = 24;
    localparam int CT_W      = 3;

    localparam logic [CT_W-1:0] CT_IO      = 3'b001;
    localparam logic [CT_W-1:0] CT_MEM     = 3'b011;
    localparam logic [CT_W-1:0] CT_CONFIG  = 3'b101;
    localparam logic [CT_W-1:0] CT_MEMMULT = 3'b111;

    localparam logic [IDX_W-1:0] MISS_IDX = IDX_W'(NUM_WIN);
endpackage

// File: rtl/xlat_regfile.sv
module xlat_regfile
    import xlat_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [ADDR_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][ADDR_W-1:0]  regs_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                regs_q[i] <= wr_data;
            end
        end

        AST_WR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(i)) |=> (regs_q[i] == $past(wr_data))); // R2
        AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == SEL_W'(i)) |=> $stable(regs_q[i])); // R2
    end
endmodule

// File: rtl/xlat_window.sv
module xlat_window
    import xlat_pkg::*;
#(
    parameter bit IO_LAYOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_reg,
    input  logic [ADDR_W-1:0] map_reg,
    input  logic [ADDR_W-1:0] lb_addr,
    output logic              match,
    output logic [ADDR_W-1:0] xaddr,
    output logic [CT_W-1:0]   ctype,
    output logic              low_en,
    output logic              pref
);
    logic              enable;
    logic [3:0]        code;
    logic [5:0]        shamt;
    logic [ADDR_W-1:0] off_mask;

    always_comb begin
        enable = base_reg[0];
        code   = base_reg[7:4];
        if (IO_LAYOUT) begin
            shamt  = 6'(IO_SHIFT);
            ctype  = CT_IO;
            low_en = 1'b1;
            pref   = 1'b0;
        end else begin
            shamt  = (code > 4'(MAX_CODE)) ? 6'(MIN_SHIFT + MAX_CODE) : 6'(MIN_SHIFT) + 6'(code);
            ctype  = map_reg[3:1];
            low_en = map_reg[0];
            pref   = base_reg[2];
        end
        off_mask = ~({ADDR_W{1'b1}} << shamt);
        match    = enable && (((lb_addr ^ base_reg) & ~off_mask) == '0);
        xaddr    = (map_reg & ~off_mask) | (lb_addr & off_mask);
        if (!low_en) begin
            xaddr[1:0] = 2'b00;
        end
    end

    AST_DISABLED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !base_reg[0] |-> !match); // R3
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !low_en) |-> (xaddr[1:0] == 2'b00)); // R7
endmodule

// File: rtl/xlat_prio.sv
module xlat_prio
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] match,
    output logic [NUM_WIN-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               miss
);
    always_comb begin
        grant = '0;
        idx   = MISS_IDX;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IDX_W'(i);
            end
        end
        miss = (grant == '0);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R4
    AST_GRANT_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~match) == '0)); // R4
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
    import xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [31:0] lb_addr,
    output logic [31:0] pci_addr,
    output logic [2:0]  cyc_type,
    output logic        ad_low_en,
    output logic        prefetch,
    output logic [1:0]  hit_win,
    output logic        miss
);
    logic [NUM_REGS-1:0][ADDR_W-1:0] regs_q;
    logic [NUM_WIN-1:0]              win_match;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  win_addr;
    logic [NUM_WIN-1:0][CT_W-1:0]    win_ct;
    logic [NUM_WIN-1:0]              win_low;
    logic [NUM_WIN-1:0]              win_pref;
    logic [NUM_WIN-1:0]              grant;
    logic [IDX_W-1:0]                sel_idx;
    logic                            no_hit;

    xlat_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xlat_window #(.IO_LAYOUT(w == IO_WIN)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .base_reg (regs_q[2*w]),
            .map_reg  (regs_q[2*w+1]),
            .lb_addr  (lb_addr),
            .match    (win_match[w]),
            .xaddr    (win_addr[w]),
            .ctype    (win_ct[w]),
            .low_en   (win_low[w]),
            .pref     (win_pref[w])
        );
    end

    xlat_prio u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .match (win_match),
        .grant (grant),
        .idx   (sel_idx),
        .miss  (no_hit)
    );

    always_comb begin
        pci_addr  = '0;
        cyc_type  = '0;
        ad_low_en = 1'b0;
        prefetch  = 1'b0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (grant[w]) begin
                pci_addr  = win_addr[w];
                cyc_type  = win_ct[w];
                ad_low_en = win_low[w];
                prefetch  = win_pref[w];
            end
        end
        hit_win = sel_idx;
        miss    = no_hit;
    end

    AST_WIN0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        win_match[0] |-> (hit_win == 2'd0)); // R4
    AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> ((win_match == '0) && (pci_addr == '0) && (hit_win == 2'd3))); // R10
    AST_IO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_win == 2'd2) |-> ((cyc_type == CT_IO) && ad_low_en && !prefetch)); // R8
endmodule

// File: tb/addr_window_xlat_tb_top.sv
module addr_window_xlat_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] lb_addr = '0;
    logic [31:0] pci_addr;
    logic [2:0]  cyc_type;
    logic        ad_low_en;
    logic        prefetch;
    logic [1:0]  hit_win;
    logic        miss;

    int errors = 0;
    int checks = 0;
    logic [31:0] sh [6];

    logic [31:0] e_addr;
    logic [2:0]  e_ct;
    logic        e_low, e_pref, e_miss;
    logic [1:0]  e_win;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_xlat dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lb_addr(lb_addr), .pci_addr(pci_addr), .cyc_type(cyc_type), .ad_low_en(ad_low_en),
        .prefetch(prefetch), .hit_win(hit_win), .miss(miss)
    );

    function automatic logic [63:0] win_size(input int w);
        int c;
        if (w == 2) return 64'h100_0000;
        c = int'(sh[2*w][7:4]);
        if (c > 9) c = 9;
        return 64'h10_0000 << c;
    endfunction

    task automatic model(input logic [31:0] a);
        logic [63:0] sz, lo;
        e_addr = '0; e_ct = '0; e_low = 0; e_pref = 0; e_miss = 1; e_win = 2'd3;
        for (int w = 0; w < 3; w++) begin
            sz = win_size(w);
            lo = {32'd0, sh[2*w]} & ~(sz - 1);
            if (e_miss && sh[2*w][0] && ({32'd0, a} >= lo) && ({32'd0, a} < lo + sz)) begin
                e_miss = 0;
                e_win = 2'(w);
                e_addr = 32'(({32'd0, sh[2*w+1]} & ~(sz - 1)) | ({32'd0, a} & (sz - 1)));
                if (w == 2) begin
                    e_ct = 3'b001; e_low = 1; e_pref = 0;
                end else begin
                    e_ct = sh[2*w+1][3:1]; e_low = sh[2*w+1][0]; e_pref = sh[2*w][2];
                end
                if (!e_low) e_addr[1:0] = 2'b00;
            end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if ({pci_addr, cyc_type, ad_low_en, prefetch, hit_win, miss} !==
            {e_addr, e_ct, e_low, e_pref, e_win, e_miss}) begin
            errors++;
            $display("FAIL %s addr=%h: actual pci=%h ct=%b low=%b pf=%b win=%0d miss=%b expected pci=%h ct=%b low=%b pf=%b win=%0d miss=%b",
                     tag, lb_addr, pci_addr, cyc_type, ad_low_en, prefetch, hit_win, miss,
                     e_addr, e_ct, e_low, e_pref, e_win, e_miss);
        end
    endtask

    task automatic check_addr(input logic [31:0] a, input string tag);
        @(negedge clk);
        lb_addr = a;
        #1;
        model(a);
        compare(tag);
    endtask

    task automatic wreg(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (idx < 6) sh[idx] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] a;
        int w;
        for (int i = 0; i < 6; i++) sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        check_addr(32'h4000_0000, "R1 reset");
        check_addr(32'h6000_0000, "R10 reset miss");

        // R2: write and translation in same cycle
        @(negedge clk);
        lb_addr = 32'h4123_4567;
        wr_en = 1; wr_sel = 3'd0; wr_data = 32'h4000_0081;
        #1; model(lb_addr); compare("R2 before edge");
        @(negedge clk);
        wr_en = 0; sh[0] = 32'h4000_0081;
        #1; model(lb_addr); compare("R2 after edge");

        wreg(1, 32'h0000_0006);
        check_addr(32'h4123_4567, "R5 R7 mem low forced");
        wreg(2, 32'h5000_0085);
        wreg(3, 32'h1000_000E);
        check_addr(32'h5000_0013, "R9 R6 memmult prefetch");
        wreg(4, 32'h6000_0001);
        wreg(5, 32'h0000_000B);
        check_addr(32'h60AB_CDEF, "R8 io window");
        wreg(0, 32'h4000_0091);
        check_addr(32'h5000_0010, "R4 win0 hides win1");
        wreg(2, 32'h6100_0041);
        wreg(3, 32'h0000_000B);
        check_addr(32'h6100_0803, "R6 R7 config window");
        check_addr(32'h6000_0004, "R8 io beside config");
        wreg(0, 32'h4000_00F1);
        check_addr(32'h5FFF_FFFC, "R3 clamp top");
        check_addr(32'h3FFF_FFFC, "R3 below base");
        wreg(4, 32'h6000_0000);
        check_addr(32'h6080_0000, "R10 disabled miss");
        wreg(6, 32'hFFFF_FFFF);
        wreg(7, 32'hFFFF_FFFF);
        check_addr(32'h6080_0000, "R2 sel 6 7 ignored");

        void'($urandom(32'd4242));
        for (int it = 0; it < 400; it++) begin
            if (it % 25 == 0) begin
                for (int r = 0; r < 6; r++) begin
                    logic [31:0] d;
                    d = $urandom();
                    if (r % 2 == 0) begin
                        d[31:28] = 4'h4 + 4'($urandom_range(0, 2));
                        d[0] = ($urandom_range(0, 4) != 0);
                        case ($urandom_range(0, 3))
                            0: d[7:4] = 4'd4;
                            1: d[7:4] = 4'd8;
                            2: d[7:4] = 4'd9;
                            default: d[7:4] = 4'($urandom_range(0, 15));
                        endcase
                    end
                    wreg(r, d);
                end
            end
            w = $urandom_range(0, 3);
            if (w == 3) a = $urandom();
            else a = (sh[2*w] & 32'hFFF0_0000) + ($urandom() >> $urandom_range(3, 12));
            check_addr(a, (it % 2 == 0) ? "R5 random" : "R4 random overlap");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule